// File: doc/BRIEF.md
# Keyed-Commit Flash Control Register Bank

This block holds the settings that govern a flash array: a three-bit operating mode, a bit that makes the boot ROM visible, and a two-bit selector that picks what the upper half of the data address space reaches. Software programs these settings through a small 8-bit register port. A write to the settings register fills only a staging copy. The working copy, which drives every output, changes only when software writes one fixed key byte to a separate commit register. The working copy has its own read-only address, so software can read both the staged value and the value in force.

From the working copy the block derives a command-enable line, a matching flash-active status line and a boot-ROM overlay enable. It also contains the address steering for data accesses. Each access arrives on a valid/ready channel. The block sends it either to the data-area port or to the code-area port, and it does not change the address. Back-pressure comes from the selected port alone: `acc_ready` follows the ready of the port that receives the current access. The port that is not selected sees no valid. An access counts as taken in a cycle where `acc_valid` and `acc_ready` are both high.

Settings byte layout (staging and working copy): bits 7:5 hold the mode, bit 4 holds the boot-ROM visibility bit, bits 3:2 hold the area selector, and bits 1:0 always read as 0. Register offsets on `reg_addr`: 0 is staging (read/write), 1 is commit (write-only), 2 is the working copy (read-only), and 3 is unmapped.

Top module: `flash_ctl_keyed`

## Requirements
- R1: After reset, both staging and the working copy read 0x40 (mode 3'b010, boot bit 0, area 2'b00). `cmd_en`, `flash_active`, `boot_en` and `cfg_err` are all low.
- R2: A write to offset 0 stores `reg_wdata[7:2]` in staging, and a later read of offset 0 returns it with bits 1:0 as 0. That write leaves the working copy and all outputs unchanged.
- R3: A write of 0xD5 to offset 1 loads the working copy from staging at that clock edge. The new value is visible on the outputs in the following cycle.
- R4: A write of any other value to offset 1 changes nothing. A read of offset 1 returns 0x00.
- R5: `cmd_en` and `flash_active` are high exactly when the working mode equals 3'b101. Mode 3'b010 means disabled, and all other mode codes are reserved.
- R6: `boot_en` equals the working visibility bit (1 = boot ROM shown). A commit always loads this bit.
- R7: At a commit, a reserved staged mode (anything but 3'b010 or 3'b101) leaves the working mode as it was. A reserved staged area (2'b01 or 2'b11) leaves the working area as it was. Either case sets `cfg_err`, and `cfg_err` stays high until reset.
- R8: An access with address bit 15 clear goes to the data port. An access with bit 15 set goes to the code port when the working area is 2'b10, and to the data port otherwise. The address passes through unchanged. Only the selected port sees valid, and `acc_ready` is that port's ready.
- R9: A read (`reg_rd` high) updates `reg_rdata` at the clock edge and returns the value held just before that edge. Offset 3 reads 0x00. `reg_rdata` holds its value when no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cmd_en | output | 1 | Command sequence and toggle execution enabled |
| flash_active | output | 1 | Flash held in active state |
| boot_en | output | 1 | Boot ROM overlay visible |
| cfg_err | output | 1 | Sticky flag: a reserved value was committed |
| acc_valid | input | 1 | Data access valid |
| acc_addr | input | 16 | Data access address |
| acc_ready | output | 1 | Data access accepted by the selected port |
| dport_valid | output | 1 | Valid toward the data area |
| dport_addr | output | 16 | Address toward the data area |
| dport_ready | input | 1 | Data area ready |
| cport_valid | output | 1 | Valid toward the code area |
| cport_addr | output | 16 | Address toward the code area |
| cport_ready | input | 1 | Code area ready |

## Verification
A commit and an upper-half access can fall in the same cycle. In that case the access must be steered by the old working area, and the next access by the new one. The bench forces this case: it stages area 2'b00 while 2'b10 is in force, then asserts a commit and an access at 0x9000 together. It checks the code-port valid before the edge and the data-port valid after it. A read of the working copy and a commit can also coincide only through the single address bus. This is judged by the behavioural reference model, which compares `reg_rdata`, every flag and every routing output on every clock during directed and random traffic.

// File: rtl/fkc_pkg.sv
package fkc_pkg;
  typedef struct packed {
    logic [2:0] mode;
    logic       boot;
    logic [1:0] area;
  } fkc_cfg_t;

  localparam logic [2:0] MODE_OFF  = 3'b010;
  localparam logic [2:0] MODE_ON   = 3'b101;
  localparam logic [1:0] AREA_STD  = 2'b00;
  localparam logic [1:0] AREA_CODE = 2'b10;

  localparam int OFS_STAGE  = 0;
  localparam int OFS_COMMIT = 1;
  localparam int OFS_ACTIVE = 2;

  localparam fkc_cfg_t CFG_RESET = '{mode: MODE_OFF, boot: 1'b0, area: AREA_STD};

  function automatic logic [7:0] cfg_to_byte(input fkc_cfg_t c);
    return {c.mode, c.boot, c.area, 2'b00};
  endfunction
endpackage

// File: rtl/fkc_regfile.sv
module fkc_regfile
  import fkc_pkg::*;
#(
  parameter int         OFS_W = 2,
  parameter logic [7:0] KEY   = 8'hD5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [OFS_W-1:0] ofs,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output fkc_cfg_t         stage_cfg,
  output fkc_cfg_t         act_cfg,
  output logic             err
);
  fkc_cfg_t stage_q, act_q, act_d;
  logic     err_q;
  logic [7:0] rdata_q;
  logic     commit, mode_ok, area_ok;
  logic [1:0] unused_lo;

  assign unused_lo = wdata[1:0];
  assign commit    = wr && (ofs == OFS_W'(OFS_COMMIT)) && (wdata == KEY);

  // legality of the staged fields is judged at the commit edge
  always_comb begin
    mode_ok = (stage_q.mode == MODE_OFF) || (stage_q.mode == MODE_ON);
    area_ok = (stage_q.area == AREA_STD) || (stage_q.area == AREA_CODE);
    act_d   = act_q;
    if (commit) begin
      act_d.boot = stage_q.boot;
      if (mode_ok) act_d.mode = stage_q.mode;
      if (area_ok) act_d.area = stage_q.area;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= CFG_RESET;
      act_q   <= CFG_RESET;
      err_q   <= 1'b0;
      rdata_q <= 8'h00;
    end else begin
      if (wr && (ofs == OFS_W'(OFS_STAGE)))
        stage_q <= '{mode: wdata[7:5], boot: wdata[4], area: wdata[3:2]};
      act_q <= act_d;
      if (commit && !(mode_ok && area_ok)) err_q <= 1'b1;
      if (rd) begin
        if (ofs == OFS_W'(OFS_STAGE))       rdata_q <= cfg_to_byte(stage_q);
        else if (ofs == OFS_W'(OFS_ACTIVE)) rdata_q <= cfg_to_byte(act_q);
        else                                rdata_q <= 8'h00;
      end
    end
  end

  assign rdata     = rdata_q;
  assign stage_cfg = stage_q;
  assign act_cfg   = act_q;
  assign err       = err_q;
endmodule

// File: rtl/fkc_decode.sv
module fkc_decode
  import fkc_pkg::*;
(
  input  fkc_cfg_t act_cfg,
  output logic     cmd_en,
  output logic     flash_active,
  output logic     boot_en,
  output logic     code_remap
);
  logic run;
  assign run          = (act_cfg.mode == MODE_ON);
  assign cmd_en       = run;
  assign flash_active = run;
  assign boot_en      = act_cfg.boot;
  assign code_remap   = (act_cfg.area == AREA_CODE);
endmodule

// File: rtl/fkc_router.sv
module fkc_router #(
  parameter int ADDR_W = 16
) (
  input  logic              code_remap,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_ready,
  output logic              dport_valid,
  output logic [ADDR_W-1:0] dport_addr,
  input  logic              dport_ready,
  output logic              cport_valid,
  output logic [ADDR_W-1:0] cport_addr,
  input  logic              cport_ready
);
  localparam int UPPER_BIT = ADDR_W - 1;
  logic to_code;

  assign to_code     = acc_addr[UPPER_BIT] && code_remap;
  assign dport_valid = acc_valid && !to_code;
  assign cport_valid = acc_valid && to_code;
  assign dport_addr  = acc_addr;
  assign cport_addr  = acc_addr;
  assign acc_ready   = to_code ? cport_ready : dport_ready;
endmodule

// File: rtl/flash_ctl_keyed.sv
module flash_ctl_keyed
  import fkc_pkg::*;
#(
  parameter int         ADDR_W = 16,
  parameter int         OFS_W  = 2,
  parameter logic [7:0] KEY    = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              cmd_en,
  output logic              flash_active,
  output logic              boot_en,
  output logic              cfg_err,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_ready,
  output logic              dport_valid,
  output logic [ADDR_W-1:0] dport_addr,
  input  logic              dport_ready,
  output logic              cport_valid,
  output logic [ADDR_W-1:0] cport_addr,
  input  logic              cport_ready
);
  fkc_cfg_t stage_cfg, act_cfg;
  logic     code_remap;

  fkc_regfile #(.OFS_W(OFS_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .ofs(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .stage_cfg(stage_cfg),
    .act_cfg(act_cfg), .err(cfg_err)
  );

  fkc_decode u_dec (
    .act_cfg(act_cfg), .cmd_en(cmd_en), .flash_active(flash_active),
    .boot_en(boot_en), .code_remap(code_remap)
  );

  fkc_router #(.ADDR_W(ADDR_W)) u_route (
    .code_remap(code_remap), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_ready(acc_ready), .dport_valid(dport_valid), .dport_addr(dport_addr),
    .dport_ready(dport_ready), .cport_valid(cport_valid),
    .cport_addr(cport_addr), .cport_ready(cport_ready)
  );
endmodule

// File: rtl/fkc_checker.sv
module fkc_checker
  import fkc_pkg::*;
#(
  parameter int         ADDR_W = 16,
  parameter int         OFS_W  = 2,
  parameter logic [7:0] KEY    = 8'hD5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [OFS_W-1:0]  reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              cmd_en,
  input logic              flash_active,
  input logic              cfg_err,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              dport_valid,
  input logic              cport_valid,
  input fkc_cfg_t          stage_cfg,
  input fkc_cfg_t          act_cfg
);
  logic key_wr;
  assign key_wr = reg_wr && (reg_addr == OFS_W'(OFS_COMMIT)) && (reg_wdata == KEY);

  assert_no_commit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(act_cfg));

  assert_cmd_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en == (act_cfg.mode == MODE_ON)) && (flash_active == cmd_en));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  assert_bad_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && (stage_cfg.mode != MODE_OFF) && (stage_cfg.mode != MODE_ON))
      |=> ($stable(act_cfg.mode) && cfg_err));

  assert_lower_to_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_addr[ADDR_W-1]) |-> (dport_valid && !cport_valid));

  assert_one_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dport_valid, cport_valid}));

  assert_commit_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == OFS_W'(OFS_COMMIT))) |=> (reg_rdata == 8'h00));

  assert_hole_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == OFS_W'(3))) |=> (reg_rdata == 8'h00));
endmodule

bind flash_ctl_keyed fkc_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .KEY(KEY)) u_fkc_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_en(cmd_en),
  .flash_active(flash_active), .cfg_err(cfg_err), .acc_valid(acc_valid),
  .acc_addr(acc_addr), .dport_valid(dport_valid), .cport_valid(cport_valid),
  .stage_cfg(stage_cfg), .act_cfg(act_cfg)
);

// File: tb/test_flash_ctl_keyed.sv
`timescale 1ns/1ps
module test_flash_ctl_keyed;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic cmd_en, flash_active, boot_en, cfg_err;
  logic acc_valid = 0;
  logic [15:0] acc_addr = 0;
  logic acc_ready, dport_valid, cport_valid;
  logic [15:0] dport_addr, cport_addr;
  logic dport_ready = 1, cport_ready = 1;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  flash_ctl_keyed i_flash_ctl_keyed (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_stage, m_rdata;
  logic [2:0] m_mode;
  logic       m_boot, m_err;
  logic [1:0] m_area;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage <= 8'h40; m_rdata <= 8'h00; m_mode <= 3'b010;
      m_boot <= 1'b0; m_area <= 2'b00; m_err <= 1'b0;
    end else begin
      if (reg_rd) begin
        case (reg_addr)
          2'd0:    m_rdata <= m_stage;
          2'd2:    m_rdata <= {m_mode, m_boot, m_area, 2'b00};
          default: m_rdata <= 8'h00;
        endcase
      end
      if (reg_wr && reg_addr == 2'd0) m_stage <= {reg_wdata[7:2], 2'b00};
      if (reg_wr && reg_addr == 2'd1 && reg_wdata == 8'hD5) begin
        m_boot <= m_stage[4];
        if (m_stage[7:5] == 3'b010 || m_stage[7:5] == 3'b101) m_mode <= m_stage[7:5];
        else m_err <= 1'b1;
        if (m_stage[3:2] == 2'b00 || m_stage[3:2] == 2'b10) m_area <= m_stage[3:2];
        else m_err <= 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    if (cmp_on) begin
      bit to_code;
      #2;
      to_code = acc_addr >= 16'h8000 && m_area == 2'b10;
      chk("R9 rdata", reg_rdata, m_rdata);
      chk("R5 cmd_en", cmd_en, m_mode == 3'b101);
      chk("R5 flash_active", flash_active, m_mode == 3'b101);
      chk("R6 boot_en", boot_en, m_boot);
      chk("R7 cfg_err", cfg_err, m_err);
      chk("R8 dport_valid", dport_valid, acc_valid && !to_code);
      chk("R8 cport_valid", cport_valid, acc_valid && to_code);
      chk("R8 acc_ready", acc_ready, to_code ? cport_ready : dport_ready);
      if (dport_valid) chk("R8 dport_addr", dport_addr, acc_addr);
      if (cport_valid) chk("R8 cport_addr", cport_addr, acc_addr);
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(posedge clk); #2 chk(req, reg_rdata, exp);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    // R1 reset state
    chk("R1 cmd_en", cmd_en, 0); chk("R1 boot_en", boot_en, 0); chk("R1 cfg_err", cfg_err, 0);
    rd_chk(2'd0, 8'h40, "R1 staging");
    rd_chk(2'd2, 8'h40, "R1 active");
    // R2 staging only
    wr_reg(2'd0, 8'hBB);
    rd_chk(2'd0, 8'hB8, "R2 staged readback");
    rd_chk(2'd2, 8'h40, "R2 active untouched");
    chk("R2 cmd_en still low", cmd_en, 0);
    // R4 wrong key
    wr_reg(2'd1, 8'h55);
    rd_chk(2'd2, 8'h40, "R4 wrong key ignored");
    rd_chk(2'd1, 8'h00, "R4 commit reads zero");
    // R3 commit
    wr_reg(2'd1, 8'hD5);
    chk("R3 cmd_en", cmd_en, 1); chk("R6 boot shown", boot_en, 1);
    rd_chk(2'd2, 8'hB8, "R3 active loaded");
    // R8 routing, lower half and upper half with code remap
    @(negedge clk); acc_valid = 1; acc_addr = 16'h1234; cport_ready = 0; dport_ready = 1;
    #1 chk("R8 lower to data", {dport_valid, cport_valid, acc_ready}, 3'b101);
    @(negedge clk); acc_addr = 16'h9000;
    #1 chk("R8 upper to code", {dport_valid, cport_valid, acc_ready}, 3'b010);
    // same cycle: commit area 00 while an upper access is presented
    @(negedge clk); acc_valid = 0; cport_ready = 1;
    wr_reg(2'd0, 8'hA0);
    @(negedge clk); reg_wr = 1; reg_addr = 2'd1; reg_wdata = 8'hD5;
    acc_valid = 1; acc_addr = 16'h9000;
    #1 chk("R8 old mapping in commit cycle", cport_valid, 1);
    @(negedge clk); reg_wr = 0;
    #1 chk("R3 new mapping next cycle", {dport_valid, cport_valid}, 2'b10);
    @(negedge clk); acc_valid = 0;
    // R7 reserved values
    wr_reg(2'd0, 8'h64);
    wr_reg(2'd1, 8'hD5);
    chk("R7 err set", cfg_err, 1);
    rd_chk(2'd2, 8'hA0, "R7 fields held, boot loaded");
    wr_reg(2'd0, 8'h48);
    wr_reg(2'd1, 8'hD5);
    chk("R7 err sticky", cfg_err, 1);
    rd_chk(2'd2, 8'h48, "R7 legal commit after error");
    rd_chk(2'd3, 8'h00, "R9 hole reads zero");
    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      reg_wr    = ($urandom % 3) == 0;
      reg_rd    = ($urandom % 2) == 0;
      reg_addr  = 2'($urandom);
      reg_wdata = (($urandom % 3) == 0) ? 8'hD5 : 8'($urandom);
      acc_valid = ($urandom % 2) == 0;
      acc_addr  = 16'($urandom);
      dport_ready = ($urandom % 2) == 0;
      cport_ready = ($urandom % 2) == 0;
    end
    @(negedge clk); reg_wr = 0; reg_rd = 0; acc_valid = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule